// File: doc/BRIEF.md
# Register-Staged Memory Access Unit

This block sits between a processing unit and a small synchronous word store. A requester issues a load or a store. The unit then moves the access through two explicit staging registers: an address register that selects the word, and a data register that carries the word in either direction. No address or data ever reaches the array except through those registers. Each access advances one step per clock, in a fixed order.

A load first places the address in the address register. Next it raises the read strobe, which captures the selected word into the data register. Then it signals completion, and the requester takes the word from the data register. A store fills the data register first, then the address register, and then raises the write strobe in its final cycle.

The store has 2^ADDR_W words of DATA_W bits each and is held inside the block as a register array. The unit takes one command at a time. While it is busy, `cmd_ready` stays low.

Top module: `staged_mem_unit`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits. A load returns the word most recently stored at the same address.
- R2: The accept edge is a rising clock edge at which both `cmd_valid` and `cmd_ready` are high. The cycles after it are numbered from 1. For a load (`cmd_write`=0), the address register shows the command address from cycle 2. `rd_stb` is high in cycle 2 only. The data register shows the array word from cycle 3.
- R3: For a store (`cmd_write`=1), the data register shows the write data from cycle 2. The address register shows the command address from cycle 3. `wr_stb` is high in cycle 3, and the array holds the new word after that cycle.
- R4: For both loads and stores, `done` is high in cycle 3 only and low at all other times.
- R5: `rd_stb` and `wr_stb` are never high in the same cycle. Neither strobe stays high for two consecutive cycles.
- R6: `cmd_ready` is high only while the unit is idle. It is low in cycles 1 to 3 and high again in cycle 4. A command presented while `cmd_ready` is low is ignored and leaves the array unchanged.
- R7: `rst_n` is a synchronous, active-low reset. It returns the unit to idle (`cmd_ready` high) and clears both staging registers to zero, including in the middle of an access, which is then abandoned. It does not alter the array.
- R8: While the unit is idle, both staging registers keep their values. A loaded word therefore stays visible on `mdr_q` until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_wdata | input | DATA_W | Data for a store |
| cmd_ready | output | 1 | Unit idle, command will be accepted |
| mar_q | output | ADDR_W | Address staging register |
| mdr_q | output | DATA_W | Data staging register; load result |
| rd_stb | output | 1 | Array read strobe |
| wr_stb | output | 1 | Array write strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with ADDR_W=3 and DATA_W=8. With eight words, the stimulus can reach both the lowest and highest addresses and overwrite a word, and it can still keep track of every location the test touches. With 8-bit data, all-zero, all-one and alternating-bit patterns pass through the data register. This narrow configuration also lets a single location stay untouched until it is read back. That makes the effect of an ignored command while busy and the effect of a mid-access reset show up as a plain read-back mismatch.

// File: rtl/smu_pkg.sv
// Package: shared types for the register-staged memory access unit.
// Assumes: only the sequencer decodes these states.
package smu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_LD_ADDR  = 3'd1,
        ST_LD_READ  = 3'd2,
        ST_LD_DONE  = 3'd3,
        ST_ST_DATA  = 3'd4,
        ST_ST_ADDR  = 3'd5,
        ST_ST_WRITE = 3'd6
    } smu_state_e;

endpackage

// File: rtl/smu_sequencer.sv
// Module: step sequencer. Walks a load or a store through its three
// one-cycle steps and decodes the register enables and the array strobes.
// Assumes: one command is in flight at a time; rst_n is synchronous.
module smu_sequencer
    import smu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_write,
    output logic ready,
    output logic take_cmd,
    output logic load_mar,
    output logic load_mdr_wdata,
    output logic load_mdr_array,
    output logic rd_stb,
    output logic wr_stb,
    output logic done
);

    smu_state_e state_q, state_d;

    // Purpose: choose the next step of the current access.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid) state_d = cmd_write ? ST_ST_DATA : ST_LD_ADDR;
            ST_LD_ADDR:  state_d = ST_LD_READ;
            ST_LD_READ:  state_d = ST_LD_DONE;
            ST_LD_DONE:  state_d = ST_IDLE;
            ST_ST_DATA:  state_d = ST_ST_ADDR;
            ST_ST_ADDR:  state_d = ST_ST_WRITE;
            ST_ST_WRITE: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Purpose: hold the step register; reset returns it to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: decode the enables and strobes from the current step.
    always_comb begin
        ready          = (state_q == ST_IDLE);
        take_cmd       = ready && cmd_valid;
        load_mar       = (state_q == ST_LD_ADDR) || (state_q == ST_ST_ADDR);
        load_mdr_wdata = (state_q == ST_ST_DATA);
        rd_stb         = (state_q == ST_LD_READ);
        load_mdr_array = rd_stb;
        wr_stb         = (state_q == ST_ST_WRITE);
        done           = (state_q == ST_LD_DONE) || wr_stb;
    end

endmodule

// File: rtl/smu_stage_regs.sv
// Module: command latch plus the address and data staging registers.
// Assumes: the enables come from the sequencer, and at most one of
// load_mdr_wdata and load_mdr_array is high in any cycle.
module smu_stage_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_cmd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              load_mar,
    input  logic              load_mdr_wdata,
    input  logic              load_mdr_array,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mdr_q
);

    logic [ADDR_W-1:0] hold_addr_q;
    logic [DATA_W-1:0] hold_data_q;

    // Purpose: capture the command fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr_q <= '0;
            hold_data_q <= '0;
        end else if (take_cmd) begin
            hold_addr_q <= cmd_addr;
            hold_data_q <= cmd_wdata;
        end
    end

    // Purpose: address staging register, loaded in its step only.
    always_ff @(posedge clk) begin
        if (!rst_n)        mar_q <= '0;
        else if (load_mar) mar_q <= hold_addr_q;
    end

    // Purpose: data staging register, fed by the command or by the array.
    always_ff @(posedge clk) begin
        if (!rst_n)              mdr_q <= '0;
        else if (load_mdr_wdata) mdr_q <= hold_data_q;
        else if (load_mdr_array) mdr_q <= array_rdata;
    end

endmodule

// File: rtl/smu_storage.sv
// Module: word store of 2^ADDR_W words, each DATA_W bits wide.
// Read is combinational from the address, write is on the clock edge.
// Assumes: the contents are not reset and only staged values address it.
module smu_storage #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Purpose: one write-enabled register per word.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && (addr == ADDR_W'(i))) words[i] <= wdata;
        end
    end

    // Purpose: select the addressed word for the data register.
    always_comb rdata = words[addr];

endmodule

// File: rtl/staged_mem_unit.sv
// Module: top of the register-staged memory access unit. It joins the
// sequencer, the staging registers and the word store.
// Assumes: the requester holds its command until cmd_ready is seen.
module staged_mem_unit #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mdr_q,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              done
);

    logic              take_cmd;
    logic              load_mar;
    logic              load_mdr_wdata;
    logic              load_mdr_array;
    logic [DATA_W-1:0] array_rdata;

    smu_sequencer u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_write      (cmd_write),
        .ready          (cmd_ready),
        .take_cmd       (take_cmd),
        .load_mar       (load_mar),
        .load_mdr_wdata (load_mdr_wdata),
        .load_mdr_array (load_mdr_array),
        .rd_stb         (rd_stb),
        .wr_stb         (wr_stb),
        .done           (done)
    );

    smu_stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk            (clk),
        .rst_n          (rst_n),
        .take_cmd       (take_cmd),
        .cmd_addr       (cmd_addr),
        .cmd_wdata      (cmd_wdata),
        .load_mar       (load_mar),
        .load_mdr_wdata (load_mdr_wdata),
        .load_mdr_array (load_mdr_array),
        .array_rdata    (array_rdata),
        .mar_q          (mar_q),
        .mdr_q          (mdr_q)
    );

    smu_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .wr_en (wr_stb),
        .addr  (mar_q),
        .wdata (mdr_q),
        .rdata (array_rdata)
    );

endmodule

// File: rtl/smu_checker.sv
// Module: protocol checker for staged_mem_unit, attached through bind.
// Assumes: it watches top-level ports only.
module smu_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] mar_q,
    input logic [DATA_W-1:0] mdr_q,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic              done
);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    p_rd_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    p_wr_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_read_then_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> done);

    p_write_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> done);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_idle_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);

    p_reset_clears_r7: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && mar_q == '0 && mdr_q == '0));

    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd_ready) && cmd_ready) |-> ($stable(mdr_q) && $stable(mar_q)));

endmodule

bind staged_mem_unit smu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .mar_q     (mar_q),
    .mdr_q     (mdr_q),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .done      (done)
);

// File: tb/tb_staged_mem_unit.sv
`timescale 1ns/1ps
module tb_staged_mem_unit;

    localparam int AW = 3;
    localparam int DW = 8;
    localparam int NV = 12;

    // Vector layout: {write, addr[2:0], data[7:0]}; for a load, data is the expected word.
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 3'd0, 8'hA5}, {1'b1, 3'd7, 8'hFF}, {1'b1, 3'd3, 8'h3C},
        {1'b1, 3'd1, 8'h01}, {1'b0, 3'd0, 8'hA5}, {1'b0, 3'd7, 8'hFF},
        {1'b0, 3'd3, 8'h3C}, {1'b1, 3'd3, 8'hC3}, {1'b0, 3'd3, 8'hC3},
        {1'b0, 3'd1, 8'h01}, {1'b1, 3'd0, 8'h00}, {1'b0, 3'd0, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_ready;
    logic [AW-1:0] mar_q;
    logic [DW-1:0] mdr_q;
    logic          rd_stb;
    logic          wr_stb;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    staged_mem_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .mar_q(mar_q), .mdr_q(mdr_q), .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives one command from a negedge and checks every step; returns at the negedge of cycle 4.
    task automatic run_cmd(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R6 ready low in cycle 1", 32'(cmd_ready), 0);
        check("R5 no strobe in cycle 1", 32'(rd_stb | wr_stb), 0);
        @(posedge clk);
        @(negedge clk);
        if (!w) begin
            check("R2 address register in cycle 2", 32'(mar_q), 32'(a));
            check("R2 read strobe in cycle 2", 32'(rd_stb), 1);
        end else begin
            check("R3 data register in cycle 2", 32'(mdr_q), 32'(d));
            check("R5 write strobe low in cycle 2", 32'(wr_stb), 0);
        end
        check("R4 done low in cycle 2", 32'(done), 0);
        @(posedge clk);
        @(negedge clk);
        if (!w) begin
            check("R1 R2 loaded word in data register", 32'(mdr_q), 32'(d));
            check("R5 read strobe one cycle", 32'(rd_stb), 0);
        end else begin
            check("R3 address register in cycle 3", 32'(mar_q), 32'(a));
            check("R3 write strobe in cycle 3", 32'(wr_stb), 1);
        end
        check("R4 done in cycle 3", 32'(done), 1);
        @(posedge clk);
        @(negedge clk);
        check("R6 ready again in cycle 4", 32'(cmd_ready), 1);
        check("R4 done one cycle", 32'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 ready after reset", 32'(cmd_ready), 1);
        check("R7 address register cleared", 32'(mar_q), 0);
        check("R7 data register cleared", 32'(mdr_q), 0);
        check("R4 R5 outputs quiet in reset", 32'({done, rd_stb, wr_stb}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: table walk of stores and loads
        for (int i = 0; i < NV; i++) begin
            run_cmd(VEC[i][11], VEC[i][10:8], VEC[i][7:0]);
        end

        // R8: loaded word held while idle
        run_cmd(1'b0, 3'd7, 8'hFF);
        repeat (3) @(negedge clk);
        check("R8 data register holds while idle", 32'(mdr_q), 32'hFF);
        check("R8 address register holds while idle", 32'(mar_q), 7);

        // R6: command presented while busy is ignored
        run_cmd(1'b1, 3'd6, 8'h66);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 3'd2; cmd_wdata = 8'h00;
        @(posedge clk);
        @(negedge clk);
        cmd_write = 1'b1; cmd_addr = 3'd6; cmd_wdata = 8'hEE;
        check("R6 ready low while busy", 32'(cmd_ready), 0);
        @(posedge clk);
        @(negedge clk);
        check("R6 busy command starts no write", 32'(wr_stb), 0);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R6 only the first command runs", 32'(wr_stb), 0);
        @(posedge clk);
        @(negedge clk);
        run_cmd(1'b0, 3'd6, 8'h66);

        // R7: reset mid-access abandons it and keeps the array
        run_cmd(1'b1, 3'd4, 8'h44);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 3'd4; cmd_wdata = 8'h99;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 idle after mid-access reset", 32'(cmd_ready), 1);
        check("R7 data register cleared mid-access", 32'(mdr_q), 0);
        check("R7 address register cleared mid-access", 32'(mar_q), 0);
        repeat (3) @(negedge clk);
        check("R7 no write strobe after abandon", 32'(wr_stb), 0);
        run_cmd(1'b0, 3'd4, 8'h44);
        run_cmd(1'b0, 3'd0, 8'h00);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule